// File: doc/BRIEF.md
# Nibble-Register BCD Real-Time Clock

This block keeps calendar time (seconds, minutes, hours, day of month, month, two-digit year and weekday) as individual 4-bit BCD digits. Software reaches every digit and three control registers over a small register bus with a 4-bit address and 4-bit data. An external one-cycle 1 Hz enable advances the time. The carry ripples through every field in the same clock edge, and the month length and leap years are handled.

Before software reads or sets the time, it sets a hold bit and then polls a busy flag, which marks the cycles just after an increment. A tick that arrives while hold is set is not lost. It is remembered and applied as one increment when hold clears, so software always sees a coherent snapshot. Control bits select 12-hour or 24-hour counting, stop the clock, force the time-of-day to zero, and round the time to the nearest minute. The divider that makes the 1 Hz enable and the logic that raises the periodic interrupt are separate blocks.

Top module: `nibble_bcd_rtc`

## Requirements
- R1: The address selects a register. Addresses 0x0 to 0xB are second units, second tens, minute units, minute tens, hour units, hour tens, day units, day tens, month units, month tens, year units and year tens. 0xC is the weekday, and 0xD, 0xE and 0xF are the control registers. A write stores the data nibble and a read returns it. After reset the time is 00:00:00, day 01, month 01, year 00, weekday 0, and control F reads 0x4.
- R2: On each applied tick, seconds count in BCD. 59 goes to 00 and carries into minutes. Minutes 59 goes to 00 and carries into hours.
- R3: In 24-hour mode (control F bit 2 = 1), hour 23 goes to 00 and carries into the day. Each day carry advances the weekday, which runs 0 (Sunday) to 6 and wraps from 6 to 0.
- R4: In 12-hour mode (control F bit 2 = 0), the hour-tens register holds the PM flag in bit 2 and the tens digit in bits 1:0. Hour 11 goes to 12 and toggles PM. Hour 12 goes to 01. Going from 11 PM to 12 AM carries into the day.
- R5: On a day carry, the last day of the month is 31, 30 for April, June, September and November, and 28 for February. February has 29 days when the two year digits form a multiple of four. After the last day the day goes to 01 and carries into the month.
- R6: Month 12 goes to 01 and carries into the year. Year 99 goes to 00.
- R7: Control D bit 0 is hold. A tick during hold leaves the time unchanged. Any number of ticks during hold give exactly one increment, in the edge after the hold bit clears.
- R8: Control D bit 1 reads busy. It is 1 from the edge that applies an increment until BUSY_CYCLES clock cycles have passed.
- R9: Writing control D with bit 3 set rounds the time. Seconds of 30 or more become 00 and carry into the minutes. Seconds below 30 become 00 with no carry.
- R10: While control F bit 0 is set, seconds, minutes, hours and PM are forced to zero and ignore ticks and bus writes. The calendar digits keep their values. Counting resumes from zero when the bit clears.
- R11: While control F bit 1 is set, ticks are discarded and the time does not change. Bus writes still take effect.
- R12: Control D bits 2 and 3 always read 0. Control E and control F bit 3 are plain storage and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 4 | Register address for read and write |
| bus_wr | input | 1 | Write strobe, stores bus_wdata at the rising edge |
| bus_wdata | input | 4 | Write data nibble |
| bus_rd_data | output | 4 | Read data for bus_addr (combinational) |

## Verification
The bench builds the block with BUSY_CYCLES = 3. With this value, both ends of the busy window can be checked a few cycles after a tick. The time and calendar behaviour does not depend on any parameter. Month ends, leap and non-leap February, the year wrap and every 12-hour rollover are all reached by writing the digits directly and applying one tick.

// File: rtl/rtc_nib_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the nibble BCD real-time clock.
// Assumes all time digits are held as BCD; no range checking on writes.
package rtc_nib_pkg;

    localparam int NIB_W  = 4;
    localparam int ADDR_W = 4;

    // Register addresses whose order the read/write decode depends on
    localparam logic [ADDR_W-1:0] A_SEC_U = 4'h0;
    localparam logic [ADDR_W-1:0] A_SEC_T = 4'h1;
    localparam logic [ADDR_W-1:0] A_MIN_U = 4'h2;
    localparam logic [ADDR_W-1:0] A_MIN_T = 4'h3;
    localparam logic [ADDR_W-1:0] A_HR_U  = 4'h4;
    localparam logic [ADDR_W-1:0] A_HR_T  = 4'h5;
    localparam logic [ADDR_W-1:0] A_DAY_U = 4'h6;
    localparam logic [ADDR_W-1:0] A_DAY_T = 4'h7;
    localparam logic [ADDR_W-1:0] A_MON_U = 4'h8;
    localparam logic [ADDR_W-1:0] A_MON_T = 4'h9;
    localparam logic [ADDR_W-1:0] A_YR_U  = 4'hA;
    localparam logic [ADDR_W-1:0] A_YR_T  = 4'hB;
    localparam logic [ADDR_W-1:0] A_WDAY  = 4'hC;
    localparam logic [ADDR_W-1:0] A_CTL_D = 4'hD;
    localparam logic [ADDR_W-1:0] A_CTL_E = 4'hE;
    localparam logic [ADDR_W-1:0] A_CTL_F = 4'hF;

    typedef struct packed {
        logic [NIB_W-1:0] sec_u;
        logic [NIB_W-1:0] sec_t;
        logic [NIB_W-1:0] min_u;
        logic [NIB_W-1:0] min_t;
        logic [NIB_W-1:0] hr_u;
        logic             pm;
        logic [1:0]       hr_t;
        logic [NIB_W-1:0] day_u;
        logic [NIB_W-1:0] day_t;
        logic [NIB_W-1:0] mon_u;
        logic [NIB_W-1:0] mon_t;
        logic [NIB_W-1:0] yr_u;
        logic [NIB_W-1:0] yr_t;
        logic [2:0]       wday;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{day_u: 4'd1, mon_u: 4'd1, default: '0};

    // Two-digit BCD increment with no wrap; callers handle the limit
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_calendar_step.sv
`timescale 1ns/1ps
// Combinational one-second advance of the whole BCD time value.
// Ripples seconds to year in a single evaluation; force_min treats the
// seconds as 59 (used by the round-to-minute adjust).
module rtc_calendar_step
    import rtc_nib_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      mode24,
    input  logic      force_min,
    output rtc_time_t nxt
);

    logic [7:0] sec8, min8, hr8, hr_n, day8, mon8, yr8, last8;
    logic       c_min, c_hr, c_day, c_mon, c_yr, leap;

    // Leap year test straight from BCD digits: multiple of four
    always_comb begin
        if (cur.yr_t[0]) leap = (cur.yr_u == 4'd2) || (cur.yr_u == 4'd6);
        else             leap = (cur.yr_u == 4'd0) || (cur.yr_u == 4'd4) || (cur.yr_u == 4'd8);
    end

    // Last valid day of the current month
    always_comb begin
        mon8 = {cur.mon_t, cur.mon_u};
        case (mon8)
            8'h02:                      last8 = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last8 = 8'h30;
            default:                    last8 = 8'h31;
        endcase
    end

    // Carry chain from seconds up to years
    always_comb begin
        nxt   = cur;
        sec8  = {cur.sec_t, cur.sec_u};
        min8  = {cur.min_t, cur.min_u};
        hr8   = {2'b00, cur.hr_t, cur.hr_u};
        day8  = {cur.day_t, cur.day_u};
        yr8   = {cur.yr_t, cur.yr_u};
        hr_n  = hr8;
        c_day = 1'b0;

        c_min = force_min | (sec8 == 8'h59);
        {nxt.sec_t, nxt.sec_u} = c_min ? 8'h00 : bcd_inc(sec8);

        c_hr = c_min & (min8 == 8'h59);
        if (c_min) {nxt.min_t, nxt.min_u} = c_hr ? 8'h00 : bcd_inc(min8);

        if (c_hr) begin
            if (mode24) begin
                if (hr8 == 8'h23) begin
                    hr_n  = 8'h00;
                    c_day = 1'b1;
                end else begin
                    hr_n = bcd_inc(hr8);
                end
            end else begin
                case (hr8)
                    8'h11: begin
                        hr_n   = 8'h12;
                        nxt.pm = ~cur.pm;
                        c_day  = cur.pm;
                    end
                    8'h12:   hr_n = 8'h01;
                    default: hr_n = bcd_inc(hr8);
                endcase
            end
        end
        nxt.hr_t = hr_n[5:4];
        nxt.hr_u = hr_n[3:0];

        c_mon = c_day & (day8 == last8);
        if (c_day) begin
            {nxt.day_t, nxt.day_u} = c_mon ? 8'h01 : bcd_inc(day8);
            nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
        end

        c_yr = c_mon & (mon8 == 8'h12);
        if (c_mon) {nxt.mon_t, nxt.mon_u} = c_yr ? 8'h01 : bcd_inc(mon8);
        if (c_yr)  {nxt.yr_t, nxt.yr_u} = (yr8 == 8'h99) ? 8'h00 : bcd_inc(yr8);
    end

    logic unused_hr_hi;
    assign unused_hr_hi = ^hr_n[7:6];

endmodule

// File: rtl/rtc_seq_ctl.sv
`timescale 1ns/1ps
// Tick sequencing: decides when an increment is applied, remembers one
// tick that arrives during hold, and drives the busy window.
// Assumes tick is a single-cycle pulse far apart relative to BUSY_CYCLES.
module rtc_seq_ctl #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic stop,
    input  logic clr,
    output logic apply,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

    logic             pending;
    logic             tick_ok;
    logic [CNT_W-1:0] busy_cnt;

    assign tick_ok = tick & ~stop & ~clr;
    assign apply   = ~hold & ~stop & ~clr & (pending | tick_ok);
    assign busy    = (busy_cnt != '0);

    // Remember ticks seen under hold; keep one if a tick meets a pending one
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pending <= 1'b0;
        else if (hold)     pending <= pending | tick_ok;
        else if (!stop)    pending <= pending & tick_ok;
    end

    // Busy window counter, reloaded on every applied increment
    always_ff @(posedge clk) begin
        if (!rst_n)             busy_cnt <= '0;
        else if (apply)         busy_cnt <= BUSY_LOAD;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
    end

    assert_hold_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && tick_ok) |=> pending);

    assert_busy_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> busy);

    assert_busy_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(apply));

endmodule

// File: rtl/rtc_digit_bank.sv
`timescale 1ns/1ps
// Storage for all BCD time digits: applies the step, the adjust clear,
// bus writes and the time-of-day force-to-zero, in that priority order.
// Assumes bus writes at addresses 0xD..0xF are decoded elsewhere.
module rtc_digit_bank
    import rtc_nib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              force_min,
    input  logic              sec_clear,
    input  logic              clr,
    input  logic              mode24,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    output rtc_time_t         t
);

    rtc_time_t t_step;

    rtc_calendar_step step_i (
        .cur       (t),
        .mode24    (mode24),
        .force_min (force_min),
        .nxt       (t_step)
    );

    // Digit registers: step, then adjust clear, then bus write, then force-zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t <= TIME_RST;
        end else begin
            if (step_en) t <= t_step;
            if (sec_clear) begin
                t.sec_u <= '0;
                t.sec_t <= '0;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_SEC_U: t.sec_u <= wr_data;
                    A_SEC_T: t.sec_t <= wr_data;
                    A_MIN_U: t.min_u <= wr_data;
                    A_MIN_T: t.min_t <= wr_data;
                    A_HR_U:  t.hr_u  <= wr_data;
                    A_HR_T: begin
                        t.hr_t <= wr_data[1:0];
                        t.pm   <= wr_data[2];
                    end
                    A_DAY_U: t.day_u <= wr_data;
                    A_DAY_T: t.day_t <= wr_data;
                    A_MON_U: t.mon_u <= wr_data;
                    A_MON_T: t.mon_t <= wr_data;
                    A_YR_U:  t.yr_u  <= wr_data;
                    A_YR_T:  t.yr_t  <= wr_data;
                    A_WDAY:  t.wday  <= wr_data[2:0];
                    default: ;
                endcase
            end
            if (clr) begin
                t.sec_u <= '0;
                t.sec_t <= '0;
                t.min_u <= '0;
                t.min_t <= '0;
                t.hr_u  <= '0;
                t.hr_t  <= '0;
                t.pm    <= 1'b0;
            end
        end
    end

    assert_clr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (t.sec_u == 0 && t.sec_t == 0 && t.min_u == 0 && t.min_t == 0
                 && t.hr_u == 0 && t.hr_t == 0 && !t.pm));

endmodule

// File: rtl/nibble_bcd_rtc.sv
`timescale 1ns/1ps
// Top of the nibble BCD real-time clock: control registers, the
// round-to-minute adjust decode and the read multiplexer.
// Assumes tick_1hz is a one-cycle enable from an external divider.
module nibble_bcd_rtc
    import rtc_nib_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NIB_W-1:0]  bus_wdata,
    output logic [NIB_W-1:0]  bus_rd_data
);

    rtc_time_t        t;
    logic             hold;
    logic [NIB_W-1:0] ctl_e, ctl_f;
    logic             mode24, stop, clr;
    logic             apply, busy;
    logic             adj_wr, sec_ge30, force_min, sec_clear, step_en;

    assign clr    = ctl_f[0];
    assign stop   = ctl_f[1];
    assign mode24 = ctl_f[2];

    // Control register storage written over the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= 1'b0;
            ctl_e <= '0;
            ctl_f <= 4'b0100;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTL_D: hold  <= bus_wdata[0];
                A_CTL_E: ctl_e <= bus_wdata;
                A_CTL_F: ctl_f <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Round-to-minute request decode (self-clearing strobe)
    assign adj_wr    = bus_wr && (bus_addr == A_CTL_D) && bus_wdata[3];
    assign sec_ge30  = ({t.sec_t, t.sec_u} >= 8'h30);
    assign force_min = adj_wr & sec_ge30 & ~clr;
    assign sec_clear = adj_wr & ~sec_ge30;
    assign step_en   = apply | force_min;

    rtc_seq_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .hold  (hold),
        .stop  (stop),
        .clr   (clr),
        .apply (apply),
        .busy  (busy)
    );

    rtc_digit_bank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .force_min (force_min),
        .sec_clear (sec_clear),
        .clr       (clr),
        .mode24    (mode24),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .t         (t)
    );

    // Read multiplexer over all sixteen registers
    always_comb begin
        case (bus_addr)
            A_SEC_U: bus_rd_data = t.sec_u;
            A_SEC_T: bus_rd_data = t.sec_t;
            A_MIN_U: bus_rd_data = t.min_u;
            A_MIN_T: bus_rd_data = t.min_t;
            A_HR_U:  bus_rd_data = t.hr_u;
            A_HR_T:  bus_rd_data = {1'b0, t.pm, t.hr_t};
            A_DAY_U: bus_rd_data = t.day_u;
            A_DAY_T: bus_rd_data = t.day_t;
            A_MON_U: bus_rd_data = t.mon_u;
            A_MON_T: bus_rd_data = t.mon_t;
            A_YR_U:  bus_rd_data = t.yr_u;
            A_YR_T:  bus_rd_data = t.yr_t;
            A_WDAY:  bus_rd_data = {1'b0, t.wday};
            A_CTL_D: bus_rd_data = {2'b00, busy, hold};
            A_CTL_E: bus_rd_data = ctl_e;
            default: bus_rd_data = ctl_f;
        endcase
    end

    assert_stop_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clr && !bus_wr) |=> $stable(t));

endmodule

// File: tb/nibble_bcd_rtc_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: table of set/expect vectors, then directed tests.
module nibble_bcd_rtc_tb_top;

    localparam int BUSY = 3;

    typedef struct packed {
        logic [3:0] f;
        logic [7:0] sec;
        logic [7:0] min;
        logic [3:0] h10;
        logic [3:0] h1;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] yr;
        logic [3:0] wd;
    } tv_t;

    typedef struct packed {
        logic [3:0] req;
        tv_t        stim;
        tv_t        exp;
    } vec_t;

    // Each vector: load the time, apply one tick, compare every register
    localparam vec_t VECS [12] = '{
        '{4'd2, '{4'h4,8'h56,8'h34,4'h1,4'h2,8'h15,8'h06,8'h23,4'h3}, '{4'h4,8'h57,8'h34,4'h1,4'h2,8'h15,8'h06,8'h23,4'h3}}, // R2
        '{4'd2, '{4'h4,8'h59,8'h59,4'h1,4'h0,8'h15,8'h06,8'h23,4'h3}, '{4'h4,8'h00,8'h00,4'h1,4'h1,8'h15,8'h06,8'h23,4'h3}}, // R2
        '{4'd3, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h15,8'h06,8'h23,4'h6}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h16,8'h06,8'h23,4'h0}}, // R3
        '{4'd5, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h30,8'h04,8'h23,4'h1}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h01,8'h05,8'h23,4'h2}}, // R5
        '{4'd5, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h28,8'h02,8'h23,4'h2}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h01,8'h03,8'h23,4'h3}}, // R5
        '{4'd5, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h28,8'h02,8'h24,4'h2}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h29,8'h02,8'h24,4'h3}}, // R5
        '{4'd5, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h29,8'h02,8'h24,4'h3}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h01,8'h03,8'h24,4'h4}}, // R5
        '{4'd6, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h31,8'h12,8'h99,4'h5}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h01,8'h01,8'h00,4'h6}}, // R6
        '{4'd4, '{4'h0,8'h59,8'h59,4'h1,4'h1,8'h15,8'h06,8'h23,4'h2}, '{4'h0,8'h00,8'h00,4'h5,4'h2,8'h15,8'h06,8'h23,4'h2}}, // R4
        '{4'd4, '{4'h0,8'h59,8'h59,4'h5,4'h2,8'h15,8'h06,8'h23,4'h2}, '{4'h0,8'h00,8'h00,4'h4,4'h1,8'h15,8'h06,8'h23,4'h2}}, // R4
        '{4'd4, '{4'h0,8'h59,8'h59,4'h5,4'h1,8'h15,8'h06,8'h23,4'h2}, '{4'h0,8'h00,8'h00,4'h1,4'h2,8'h16,8'h06,8'h23,4'h3}}, // R4
        '{4'd5, '{4'h4,8'h59,8'h59,4'h2,4'h3,8'h31,8'h01,8'h23,4'h0}, '{4'h4,8'h00,8'h00,4'h0,4'h0,8'h01,8'h02,8'h23,4'h1}}  // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] bus_rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nibble_bcd_rtc #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1hz    (tick_1hz),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd_data (bus_rd_data)
    );

    task automatic chk(input string tag, input logic [3:0] addr, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr %h: got %h expected %h", tag, addr, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [3:0] exp);
        bus_addr = a;
        #1;
        chk(tag, a, bus_rd_data, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input tv_t s);
        wr(4'hF, s.f);
        wr(4'h0, s.sec[3:0]);  wr(4'h1, s.sec[7:4]);
        wr(4'h2, s.min[3:0]);  wr(4'h3, s.min[7:4]);
        wr(4'h4, s.h1);        wr(4'h5, s.h10);
        wr(4'h6, s.day[3:0]);  wr(4'h7, s.day[7:4]);
        wr(4'h8, s.mon[3:0]);  wr(4'h9, s.mon[7:4]);
        wr(4'hA, s.yr[3:0]);   wr(4'hB, s.yr[7:4]);
        wr(4'hC, s.wd);
    endtask

    task automatic verify(input string tag, input tv_t e);
        expect_reg(tag, 4'h0, e.sec[3:0]); expect_reg(tag, 4'h1, e.sec[7:4]);
        expect_reg(tag, 4'h2, e.min[3:0]); expect_reg(tag, 4'h3, e.min[7:4]);
        expect_reg(tag, 4'h4, e.h1);       expect_reg(tag, 4'h5, e.h10);
        expect_reg(tag, 4'h6, e.day[3:0]); expect_reg(tag, 4'h7, e.day[7:4]);
        expect_reg(tag, 4'h8, e.mon[3:0]); expect_reg(tag, 4'h9, e.mon[7:4]);
        expect_reg(tag, 4'hA, e.yr[3:0]);  expect_reg(tag, 4'hB, e.yr[7:4]);
        expect_reg(tag, 4'hC, e.wd);       expect_reg(tag, 4'hF, e.f);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        expect_reg("R1 reset", 4'h0, 4'h0);
        expect_reg("R1 reset", 4'h5, 4'h0);
        expect_reg("R1 reset", 4'h6, 4'h1);
        expect_reg("R1 reset", 4'h8, 4'h1);
        expect_reg("R1 reset", 4'hB, 4'h0);
        expect_reg("R1 reset", 4'hC, 4'h0);
        expect_reg("R1 reset", 4'hD, 4'h0);
        expect_reg("R1 reset", 4'hF, 4'h4);

        // R1: plain write/readback at a few addresses
        wr(4'hB, 4'h7);
        expect_reg("R1 readback", 4'hB, 4'h7);
        wr(4'h3, 4'h5);
        expect_reg("R1 readback", 4'h3, 4'h5);

        // Table of load/tick/compare vectors
        for (int i = 0; i < 12; i++) begin
            load(VECS[i].stim);
            pulse_tick();
            verify($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
        end

        // R8: busy window after a tick
        load('{4'h4,8'h10,8'h00,4'h0,4'h0,8'h01,8'h01,8'h00,4'h0});
        idle(BUSY + 1);
        expect_reg("R8 idle", 4'hD, 4'h0);
        pulse_tick();
        expect_reg("R8 busy start", 4'hD, 4'h2);
        idle(BUSY - 1);
        expect_reg("R8 busy last", 4'hD, 4'h2);
        idle(1);
        expect_reg("R8 busy end", 4'hD, 4'h0);

        // R7: ticks under hold give one increment after release
        wr(4'hD, 4'h1);
        pulse_tick();
        idle(2);
        pulse_tick();
        idle(2);
        pulse_tick();
        expect_reg("R7 held", 4'h0, 4'h1);
        expect_reg("R7 held", 4'hD, 4'h1);
        wr(4'hD, 4'h0);
        idle(1);
        expect_reg("R7 release", 4'h0, 4'h2);
        idle(5);
        expect_reg("R7 one step", 4'h0, 4'h2);
        expect_reg("R7 one step", 4'h1, 4'h1);

        // R9: round up from 45 s, round down from 29 s
        wr(4'h0, 4'h5); wr(4'h1, 4'h4); wr(4'h2, 4'h0); wr(4'h3, 4'h1);
        wr(4'hD, 4'h8);
        expect_reg("R9 up", 4'h0, 4'h0);
        expect_reg("R9 up", 4'h1, 4'h0);
        expect_reg("R9 up", 4'h2, 4'h1);
        expect_reg("R9 up", 4'h3, 4'h1);
        expect_reg("R12 adj bit", 4'hD, 4'h0);
        wr(4'h0, 4'h9); wr(4'h1, 4'h2);
        wr(4'hD, 4'h8);
        expect_reg("R9 down", 4'h0, 4'h0);
        expect_reg("R9 down", 4'h1, 4'h0);
        expect_reg("R9 down", 4'h2, 4'h1);

        // R10: force-to-zero control
        wr(4'h0, 4'h7); wr(4'h2, 4'h6); wr(4'h4, 4'h5); wr(4'h6, 4'h3);
        wr(4'hF, 4'h5);
        idle(1);
        pulse_tick();
        wr(4'h0, 4'h3);
        expect_reg("R10 held zero", 4'h0, 4'h0);
        expect_reg("R10 held zero", 4'h2, 4'h0);
        expect_reg("R10 held zero", 4'h4, 4'h0);
        expect_reg("R10 calendar kept", 4'h6, 4'h3);
        wr(4'hF, 4'h4);
        idle(BUSY + 1);
        pulse_tick();
        expect_reg("R10 resume", 4'h0, 4'h1);

        // R11: stop discards ticks, writes still land
        wr(4'hF, 4'h6);
        pulse_tick();
        idle(2);
        expect_reg("R11 frozen", 4'h0, 4'h1);
        wr(4'h0, 4'h5);
        expect_reg("R11 write", 4'h0, 4'h5);
        wr(4'hF, 4'h4);
        idle(3);
        expect_reg("R11 no late step", 4'h0, 4'h5);

        // R12: control E storage, F test bit, D upper bits
        wr(4'hE, 4'hA);
        expect_reg("R12 ctl E", 4'hE, 4'hA);
        wr(4'hF, 4'hC);
        expect_reg("R12 ctl F", 4'hF, 4'hC);
        wr(4'hD, 4'h4);
        expect_reg("R12 ctl D", 4'hD, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule